// File: doc/BRIEF.md
# Cache Line Writeback Sequencer with Freeze

This block flushes a range of data-cache lines to backing memory while the cache is frozen against other requesters. A controlling agent programs a start address and a line count through a small word-addressed register port, asks for a freeze, and waits for the freeze-complete status. It then starts the flush, waits for the sync-complete status, releases the freeze and waits for the freeze status to drop. The register port is never held off by the freeze, so the controlling agent can always poll status and release the freeze.

Requesters reach the cache region through a set of access ports, each with a fixed access latency. While a freeze is pending or held, in-region accesses are not accepted. They see a stall and no error, and they complete once the freeze is released. The freeze is granted only after every in-flight in-region access has finished. The cache contents are not modelled. The block keeps one dirty bit per line of the region, sets it on an in-region write and clears it when the line is written back. A line writeback is a request/acknowledge exchange with the memory side.

Top module: `cwb_seq`

## Requirements
- R1: After reset all four registers read zero, no writeback request is raised and no access port shows a stall.
- R2: Register word 0 holds the start address and word 1 holds the line count; both read back as written. Word 2 has bit 0 = writeback busy (writing 1 starts a flush) and bit 1 = sync done. Word 3 has bit 0 = freeze mode, bit 1 = freeze enable and bit 2 = freeze done. Reads are combinational and are served in every state.
- R3: The start address is aligned down to a line boundary. Writebacks go out in ascending line order, each at a line-aligned address inside the region. The request holds its address until it is acknowledged.
- R4: After freeze enable is set, freeze done rises only once no in-region access is in flight. It falls within a few cycles of freeze enable being cleared.
- R5: With mode 0, while a freeze is pending or held, an in-region access is stalled (stall high, no acknowledge) until the freeze is released, and then it completes. Accesses outside the region are served during the freeze.
- R6: With mode 1, only in-region writes are stalled; in-region reads complete during the freeze.
- R7: A write of 1 to word 2 bit 0 is ignored unless freeze done is high. It is also ignored while a flush is in progress.
- R8: Only dirty lines inside the range produce a memory write. Clean lines are skipped but still count toward completion. A written-back line becomes clean.
- R9: A zero line count, or a range wholly outside the cache region, completes with sync done set and no line written.
- R10: A line count larger than the bus address space (4 MB) divided by the line size is clamped to that many lines.
- R11: Sync done clears when a flush is accepted and sets once the last line of the range is finished; busy reads 1 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the word at reg_sel |
| rq_valid | input | NREQ | Access request per port, held until acknowledge |
| rq_we | input | NREQ | Access is a write |
| rq_addr | input | NREQ x ADDR_W | Access byte address per port |
| rq_ack | output | NREQ | One-cycle access completion per port |
| rq_stall | output | NREQ | Request is held off by the freeze |
| wb_req | output | 1 | Line writeback request |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_ack | input | 1 | Memory accepts the line writeback |

## Verification
The hardest case to reach is a freeze request that arrives while an in-region access is still in flight. Freeze done must stay low until that access acknowledges. The bench drives the access and the freeze enable on the same cycle and polls the status every cycle until the acknowledge. The line-count clamp is also hard to reach because of the size of the address space. The bench reaches it with a range that starts exactly one maximum span below the region, so the clamped range ends at the region edge and an unclamped one would flush lines. Random access traffic with random flush ranges, some unaligned and some partly outside the region, is compared with a dirty-line model in the bench.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      CWB_R_ADDR = 2'd0,
      CWB_R_SIZE = 2'd1,
      CWB_R_SYNC = 2'd2,
      CWB_R_FRZ  = 2'd3
   } cwb_reg_e;

   localparam int SYNC_GO_BIT   = 0;
   localparam int SYNC_DONE_BIT = 1;
   localparam int FRZ_MODE_BIT  = 0;
   localparam int FRZ_EN_BIT    = 1;
   localparam int FRZ_DONE_BIT  = 2;

   typedef enum logic [1:0] {
      FZ_IDLE  = 2'd0,
      FZ_DRAIN = 2'd1,
      FZ_HOLD  = 2'd2
   } fz_state_e;

   typedef enum logic [1:0] {
      WB_IDLE = 2'd0,
      WB_SCAN = 2'd1,
      WB_WAIT = 2'd2
   } wb_state_e;
endpackage

// File: rtl/cwb_regs.sv
module cwb_regs
   import cwb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [ADDR_W-1:0] start_addr,
   output logic [REG_W-1:0]  line_cnt,
   output logic              fz_mode,
   output logic              fz_en,
   output logic              go,
   input  logic              wb_busy,
   input  logic              wb_done,
   input  logic              frozen
);
   cwb_reg_e sel;
   assign sel = cwb_reg_e'(reg_sel);

   // start pulse: combinational from the write strobe, seen by the engine at the same edge
   assign go = reg_wr && (sel == CWB_R_SYNC) && reg_wdata[SYNC_GO_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_addr <= '0;
         line_cnt   <= '0;
         fz_mode    <= 1'b0;
         fz_en      <= 1'b0;
      end else if (reg_wr) begin
         case (sel)
            CWB_R_ADDR: start_addr <= reg_wdata[ADDR_W-1:0];
            CWB_R_SIZE: line_cnt   <= reg_wdata;
            CWB_R_FRZ: begin
               fz_mode <= reg_wdata[FRZ_MODE_BIT];
               fz_en   <= reg_wdata[FRZ_EN_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         CWB_R_ADDR: reg_rdata = REG_W'(start_addr);
         CWB_R_SIZE: reg_rdata = line_cnt;
         CWB_R_SYNC: begin
            reg_rdata[SYNC_GO_BIT]   = wb_busy;
            reg_rdata[SYNC_DONE_BIT] = wb_done;
         end
         CWB_R_FRZ: begin
            reg_rdata[FRZ_MODE_BIT] = fz_mode;
            reg_rdata[FRZ_EN_BIT]   = fz_en;
            reg_rdata[FRZ_DONE_BIT] = frozen;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cwb_gate.sv
module cwb_gate
   import cwb_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          LINE_BYTES   = 32,
   parameter logic [31:0] REGION_BASE  = 32'h3C00_0000,
   parameter int          REGION_LINES = 64,
   parameter int          NREQ         = 2,
   parameter int          ACC_LAT      = 3,
   localparam int         LOFF         = $clog2(LINE_BYTES),
   localparam int         IDX_W        = $clog2(REGION_LINES),
   localparam int         SUM_W        = ADDR_W + 1,
   localparam int         LAT_W        = $clog2(ACC_LAT + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fz_en,
   input  logic                         fz_mode,
   input  logic [NREQ-1:0]              rq_valid,
   input  logic [NREQ-1:0]              rq_we,
   input  logic [NREQ-1:0][ADDR_W-1:0]  rq_addr,
   output logic [NREQ-1:0]              rq_ack,
   output logic [NREQ-1:0]              rq_stall,
   output logic                         frozen,
   output logic [NREQ-1:0]              inreg_busy,
   output logic [NREQ-1:0]              mark_en,
   output logic [NREQ-1:0][IDX_W-1:0]   mark_idx
);
   localparam logic [SUM_W-1:0] BASE_L = SUM_W'(REGION_BASE >> LOFF);
   localparam logic [SUM_W-1:0] TOP_L  = BASE_L + SUM_W'(REGION_LINES);

   fz_state_e       st;
   logic            gate_on;
   logic [NREQ-1:0] blk_busy;

   assign gate_on = (st != FZ_IDLE);
   assign frozen  = (st == FZ_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= FZ_IDLE;
      end else begin
         case (st)
            FZ_IDLE:  if (fz_en) st <= FZ_DRAIN;
            FZ_DRAIN: if (!fz_en) st <= FZ_IDLE;
                      else if (blk_busy == '0) st <= FZ_HOLD;
            FZ_HOLD:  if (!fz_en) st <= FZ_IDLE;
            default:  st <= FZ_IDLE;
         endcase
      end
   end

   for (genvar gi = 0; gi < NREQ; gi++) begin : g_port
      logic [SUM_W-1:0] line;
      logic             inr, blocked, busy, take, inr_q, we_q;
      logic [LAT_W-1:0] cnt;

      assign line    = SUM_W'(rq_addr[gi] >> LOFF);
      assign inr     = (line >= BASE_L) && (line < TOP_L);
      assign blocked = gate_on && inr && (!fz_mode || rq_we[gi]);
      assign busy    = (cnt != '0);
      assign take    = rq_valid[gi] && !busy && !blocked;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt   <= '0;
            inr_q <= 1'b0;
            we_q  <= 1'b0;
         end else if (take) begin
            cnt   <= LAT_W'(ACC_LAT);
            inr_q <= inr;
            we_q  <= rq_we[gi];
         end else if (busy) begin
            cnt <= cnt - LAT_W'(1);
         end
      end

      assign rq_ack[gi]     = (cnt == LAT_W'(1));
      assign rq_stall[gi]   = rq_valid[gi] && !busy && blocked;
      assign mark_en[gi]    = take && inr && rq_we[gi];
      assign mark_idx[gi]   = IDX_W'(line - BASE_L);
      assign inreg_busy[gi] = busy && inr_q;
      assign blk_busy[gi]   = busy && inr_q && (we_q || !fz_mode);
   end
endmodule

// File: rtl/cwb_engine.sv
module cwb_engine
   import cwb_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          LINE_BYTES   = 32,
   parameter logic [31:0] REGION_BASE  = 32'h3C00_0000,
   parameter int          REGION_LINES = 64,
   parameter int          NREQ         = 2,
   parameter int          BUS_BYTES    = 4194304,
   localparam int         LOFF         = $clog2(LINE_BYTES),
   localparam int         IDX_W        = $clog2(REGION_LINES),
   localparam int         SUM_W        = ADDR_W + 1,
   localparam int         MAX_LINES    = BUS_BYTES / LINE_BYTES
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        go,
   input  logic                        frozen,
   input  logic [ADDR_W-1:0]           start_addr,
   input  logic [REG_W-1:0]            line_cnt,
   input  logic [NREQ-1:0]             mark_en,
   input  logic [NREQ-1:0][IDX_W-1:0]  mark_idx,
   output logic                        wb_req,
   output logic [ADDR_W-1:0]           wb_addr,
   input  logic                        wb_ack,
   output logic                        busy,
   output logic                        done
);
   localparam logic [SUM_W-1:0] BASE_L = SUM_W'(REGION_BASE >> LOFF);
   localparam logic [SUM_W-1:0] TOP_L  = BASE_L + SUM_W'(REGION_LINES);

   wb_state_e               state;
   logic [IDX_W-1:0]        cur, last_q;
   logic [REGION_LINES-1:0] dirty;
   logic [SUM_W-1:0]        s_line, c_cl, e_line, lo_l, hi_l;
   logic                    empty_rng, accept, clr_en;

   always_comb begin
      s_line    = SUM_W'(start_addr >> LOFF);
      c_cl      = (line_cnt > REG_W'(MAX_LINES)) ? SUM_W'(MAX_LINES) : SUM_W'(line_cnt);
      e_line    = s_line + c_cl;
      lo_l      = (s_line > BASE_L) ? s_line : BASE_L;
      hi_l      = (e_line < TOP_L) ? e_line : TOP_L;
      empty_rng = (lo_l >= hi_l);
   end

   assign busy   = (state != WB_IDLE);
   assign accept = go && frozen && !busy;
   assign clr_en = (state == WB_WAIT) && wb_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dirty <= '0;
      end else begin
         for (int i = 0; i < NREQ; i++) begin
            if (mark_en[i]) dirty[mark_idx[i]] <= 1'b1;
         end
         if (clr_en) dirty[cur] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WB_IDLE;
         cur     <= '0;
         last_q  <= '0;
         wb_req  <= 1'b0;
         wb_addr <= '0;
         done    <= 1'b0;
      end else begin
         case (state)
            WB_IDLE: begin
               if (accept) begin
                  done   <= 1'b0;
                  cur    <= IDX_W'(lo_l - BASE_L);
                  last_q <= IDX_W'(hi_l - BASE_L - SUM_W'(1));
                  if (empty_rng) done <= 1'b1;
                  else state <= WB_SCAN;
               end
            end
            WB_SCAN: begin
               if (dirty[cur]) begin
                  wb_req  <= 1'b1;
                  wb_addr <= ADDR_W'((BASE_L + SUM_W'(cur)) << LOFF);
                  state   <= WB_WAIT;
               end else if (cur == last_q) begin
                  done  <= 1'b1;
                  state <= WB_IDLE;
               end else begin
                  cur <= cur + IDX_W'(1);
               end
            end
            WB_WAIT: begin
               if (wb_ack) begin
                  wb_req <= 1'b0;
                  if (cur == last_q) begin
                     done  <= 1'b1;
                     state <= WB_IDLE;
                  end else begin
                     cur   <= cur + IDX_W'(1);
                     state <= WB_SCAN;
                  end
               end
            end
            default: state <= WB_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cwb_seq.sv
module cwb_seq
   import cwb_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          LINE_BYTES   = 32,
   parameter logic [31:0] REGION_BASE  = 32'h3C00_0000,
   parameter int          REGION_LINES = 64,
   parameter int          NREQ         = 2,
   parameter int          ACC_LAT      = 3,
   parameter int          BUS_BYTES    = 4194304
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [1:0]                  reg_sel,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   input  logic [NREQ-1:0]             rq_valid,
   input  logic [NREQ-1:0]             rq_we,
   input  logic [NREQ-1:0][ADDR_W-1:0] rq_addr,
   output logic [NREQ-1:0]             rq_ack,
   output logic [NREQ-1:0]             rq_stall,
   output logic                        wb_req,
   output logic [ADDR_W-1:0]           wb_addr,
   input  logic                        wb_ack
);
   localparam int IDX_W = $clog2(REGION_LINES);

   if (ADDR_W > 32 || ADDR_W < 8) begin : g_chk_aw
      $error("cwb_seq: ADDR_W must be within 8..32");
   end
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_chk_line
      $error("cwb_seq: LINE_BYTES must be a power of two of at least 4");
   end
   if (REGION_LINES < 2 || (REGION_LINES & (REGION_LINES - 1)) != 0) begin : g_chk_reg
      $error("cwb_seq: REGION_LINES must be a power of two of at least 2");
   end
   if (ACC_LAT < 1 || NREQ < 1) begin : g_chk_port
      $error("cwb_seq: ACC_LAT and NREQ must be at least 1");
   end
   if (BUS_BYTES < LINE_BYTES) begin : g_chk_bus
      $error("cwb_seq: BUS_BYTES must hold at least one line");
   end

   logic [ADDR_W-1:0]            start_addr_w;
   logic [31:0]                  line_cnt_w;
   logic                         fz_mode_w, fz_en_w, go_w, frozen_w;
   logic                         wb_busy_w, wb_done_w;
   logic [NREQ-1:0]              inreg_busy_w, mark_en_w;
   logic [NREQ-1:0][IDX_W-1:0]   mark_idx_w;

   cwb_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .start_addr(start_addr_w), .line_cnt(line_cnt_w),
      .fz_mode(fz_mode_w), .fz_en(fz_en_w), .go(go_w),
      .wb_busy(wb_busy_w), .wb_done(wb_done_w), .frozen(frozen_w)
   );

   cwb_gate #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REGION_BASE(REGION_BASE),
      .REGION_LINES(REGION_LINES), .NREQ(NREQ), .ACC_LAT(ACC_LAT)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .fz_en(fz_en_w), .fz_mode(fz_mode_w),
      .rq_valid(rq_valid), .rq_we(rq_we), .rq_addr(rq_addr),
      .rq_ack(rq_ack), .rq_stall(rq_stall), .frozen(frozen_w),
      .inreg_busy(inreg_busy_w), .mark_en(mark_en_w), .mark_idx(mark_idx_w)
   );

   cwb_engine #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REGION_BASE(REGION_BASE),
      .REGION_LINES(REGION_LINES), .NREQ(NREQ), .BUS_BYTES(BUS_BYTES)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .go(go_w), .frozen(frozen_w),
      .start_addr(start_addr_w), .line_cnt(line_cnt_w),
      .mark_en(mark_en_w), .mark_idx(mark_idx_w),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
      .busy(wb_busy_w), .done(wb_done_w)
   );
endmodule

// File: rtl/cwb_seq_chk.sv
module cwb_seq_chk #(
   parameter int          ADDR_W       = 32,
   parameter int          LINE_BYTES   = 32,
   parameter logic [31:0] REGION_BASE  = 32'h3C00_0000,
   parameter int          REGION_LINES = 64,
   parameter int          NREQ         = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frozen,
   input logic              fz_mode,
   input logic [NREQ-1:0]   inreg_busy,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              sync_done
);
   localparam longint RBASE = longint'(REGION_BASE);
   localparam longint RTOP  = RBASE + longint'(REGION_LINES) * longint'(LINE_BYTES);

   // R7: line writebacks only happen under a granted freeze
   a_r7_wb_only_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> frozen);

   // R3: every writeback targets the cache region
   a_r3_wb_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> (longint'(wb_addr) >= RBASE && longint'(wb_addr) < RTOP));

   // R3: request and address hold until acknowledged
   a_r3_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

   // R4: the freeze is granted with no in-region access still in flight
   a_r4_freeze_drained: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(frozen) && !fz_mode) |-> (inreg_busy == '0));

   // R11: sync done stays low while a line is being written
   a_r11_done_low_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !sync_done);
endmodule

bind cwb_seq cwb_seq_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REGION_BASE(REGION_BASE),
   .REGION_LINES(REGION_LINES), .NREQ(NREQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frozen(frozen_w), .fz_mode(fz_mode_w),
   .inreg_busy(inreg_busy_w), .wb_req(wb_req), .wb_ack(wb_ack),
   .wb_addr(wb_addr), .sync_done(wb_done_w)
);

// File: tb/cwb_seq_tb.sv
`timescale 1ns/1ps
module cwb_seq_tb_top;
   localparam int          AW    = 32;
   localparam int          LB    = 32;
   localparam logic [31:0] RB    = 32'h3C00_0000;
   localparam int          RL    = 64;
   localparam longint      MAXL  = 4194304 / LB;
   localparam longint      BASEL = longint'(RB) / LB;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_wr = 1'b0;
   logic [1:0]         reg_sel = '0;
   logic [31:0]        reg_wdata = '0;
   logic [31:0]        reg_rdata;
   logic [1:0]         rq_valid = '0;
   logic [1:0]         rq_we = '0;
   logic [1:0][AW-1:0] rq_addr = '0;
   logic [1:0]         rq_ack, rq_stall;
   logic               wb_req;
   logic [AW-1:0]      wb_addr;
   logic               wb_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit [RL-1:0] mdl_dirty = '0;
   logic [31:0] wb_log [0:127];
   int wb_n = 0;
   logic [31:0] exp_a [0:127];
   int exp_n = 0;

   always #5 clk = ~clk;

   cwb_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .REGION_BASE(RB), .REGION_LINES(RL),
             .NREQ(2), .ACC_LAT(3), .BUS_BYTES(4194304)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rq_valid(rq_valid),
      .rq_we(rq_we), .rq_addr(rq_addr), .rq_ack(rq_ack), .rq_stall(rq_stall),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack));

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory side: random acknowledge delay, logs each written line
   initial begin
      int dly = 0;
      forever begin
         @(negedge clk);
         if (wb_ack) wb_ack = 1'b0;
         else if (wb_req) begin
            if (dly == 0) begin
               wb_ack = 1'b1;
               if (wb_n < 128) wb_log[wb_n] = wb_addr;
               wb_n++;
               dly = int'($urandom % 3);
            end else dly--;
         end
      end
   end

   task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
      reg_sel = s;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_bit(input logic [1:0] s, input int b, input bit v, input string req);
      logic [31:0] d;
      bit hit = 0;
      for (int n = 0; n < 3000 && !hit; n++) begin
         reg_read(s, d);
         if (d[b] == v) hit = 1;
         else @(negedge clk);
      end
      check(req, "status bit wait", longint'(hit), 1);
   endtask

   function automatic bit in_reg(input logic [31:0] a);
      longint l = longint'(a) / LB;
      return (l >= BASEL) && (l < BASEL + RL);
   endfunction

   task automatic access(input int p, input logic [31:0] a, input bit we, output bit ok);
      int n = 0;
      @(negedge clk);
      rq_valid[p] = 1'b1; rq_addr[p] = a; rq_we[p] = we;
      do begin @(negedge clk); n++; end while (!rq_ack[p] && n < 200);
      ok = rq_ack[p];
      rq_valid[p] = 1'b0;
      if (ok && we && in_reg(a)) mdl_dirty[int'(longint'(a) / LB - BASEL)] = 1'b1;
   endtask

   function automatic void expect_range(input logic [31:0] a, input longint cnt);
      longint s = longint'(a) / LB;
      longint c = (cnt > MAXL) ? MAXL : cnt;
      exp_n = 0;
      for (int k = 0; k < RL; k++) begin
         longint ln = BASEL + k;
         if (ln >= s && ln < s + c && mdl_dirty[k]) begin
            exp_a[exp_n] = 32'(ln * LB);
            exp_n++;
            mdl_dirty[k] = 1'b0;
         end
      end
   endfunction

   task automatic run_wb(input logic [31:0] a, input logic [31:0] cnt, input string req);
      reg_write(2'd0, a);
      reg_write(2'd1, cnt);
      reg_write(2'd3, 32'h2);
      wait_bit(2'd3, 2, 1'b1, "R4");
      expect_range(a, longint'(cnt));
      wb_n = 0;
      reg_write(2'd2, 32'h1);
      wait_bit(2'd2, 1, 1'b1, "R11");
      check(req, "line writes in range", wb_n, exp_n);
      for (int i = 0; i < exp_n && i < wb_n; i++)
         check("R3", "writeback address order", wb_log[i], exp_a[i]);
      reg_write(2'd3, 32'h0);
      wait_bit(2'd3, 2, 1'b0, "R4");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit ok, early, acked;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         reg_read(2'(s), d);
         check("R1", "register after reset", d, 0);
      end
      check("R1", "wb_req after reset", wb_req, 0);
      check("R1", "stall after reset", rq_stall, 0);

      // R2 register readback
      reg_write(2'd0, 32'h3C00_0123); reg_read(2'd0, d); check("R2", "address readback", d, 32'h3C00_0123);
      reg_write(2'd1, 32'd17);        reg_read(2'd1, d); check("R2", "size readback", d, 17);
      reg_write(2'd3, 32'h1);         reg_read(2'd3, d); check("R2", "freeze mode readback", d, 1);
      reg_write(2'd3, 32'h0);

      // random traffic and random flush ranges (R3, R8)
      for (int it = 0; it < 25; it++) begin
         for (int k = 0; k < 6; k++) begin
            logic [31:0] a;
            if ($urandom % 4 != 0) a = RB + ($urandom % (RL * LB));
            else a = RB - 32'h1000 + ($urandom % 32'h800);
            access(int'($urandom % 2), a, 1'($urandom % 2), ok);
            check("R5", "access unfrozen completes", ok, 1);
         end
         begin
            int lo = int'($urandom % 80) - 8;
            logic [31:0] a = RB + 32'(lo * LB) + ($urandom % LB);
            run_wb(a, $urandom % 41, "R8");
         end
      end

      // R9 zero count and out-of-region range
      access(0, RB + 5, 1'b1, ok);
      run_wb(RB, 32'd0, "R9");
      run_wb(RB - 32'h8000, 32'd10, "R9");
      // R10 clamp: range ends exactly at the region base after clamping
      run_wb(RB - 32'(MAXL * LB), 32'(MAXL + 5), "R10");
      run_wb(RB, 32'd64, "R8");
      run_wb(RB, 32'd64, "R8");

      // R7 trigger ignored while not frozen
      access(0, RB + 2 * LB, 1'b1, ok);
      access(1, RB + 5 * LB, 1'b1, ok);
      reg_write(2'd0, RB); reg_write(2'd1, 32'd64);
      wb_n = 0;
      reg_write(2'd2, 32'h1);
      repeat (20) @(negedge clk);
      reg_read(2'd2, d);
      check("R7", "busy after unfrozen trigger", d[0], 0);
      check("R7", "writes after unfrozen trigger", wb_n, 0);

      // R11 done clears on accepted trigger; R7 retrigger while busy ignored
      reg_write(2'd3, 32'h2);
      wait_bit(2'd3, 2, 1'b1, "R4");
      expect_range(RB, 64);
      wb_n = 0;
      reg_write(2'd2, 32'h1);
      reg_read(2'd2, d);
      check("R11", "busy and done right after trigger", d[1:0], 2'b01);
      reg_write(2'd2, 32'h1);
      wait_bit(2'd2, 1, 1'b1, "R11");
      check("R7", "retrigger gives no extra writes", wb_n, exp_n);
      reg_write(2'd3, 32'h0);
      wait_bit(2'd3, 2, 1'b0, "R4");

      // R5 mode 0 stall
      reg_write(2'd3, 32'h2);
      wait_bit(2'd3, 2, 1'b1, "R4");
      @(negedge clk);
      rq_valid[1] = 1'b1; rq_addr[1] = RB + 9 * LB; rq_we[1] = 1'b0;
      access(0, RB - 32'h100, 1'b0, ok);
      check("R5", "out-of-region access while frozen", ok, 1);
      check("R5", "in-region read stalled", rq_stall[1], 1);
      check("R5", "in-region read not acked", rq_ack[1], 0);
      reg_write(2'd3, 32'h0);
      acked = 0;
      for (int n = 0; n < 20 && !acked; n++) begin
         @(negedge clk);
         if (rq_ack[1]) acked = 1;
      end
      rq_valid[1] = 1'b0;
      check("R5", "stalled read completes after release", acked, 1);

      // R6 mode 1: reads pass, writes stall
      reg_write(2'd3, 32'h3);
      wait_bit(2'd3, 2, 1'b1, "R4");
      access(0, RB + 3 * LB, 1'b0, ok);
      check("R6", "in-region read in write-only freeze", ok, 1);
      @(negedge clk);
      rq_valid[1] = 1'b1; rq_addr[1] = RB + 11 * LB; rq_we[1] = 1'b1;
      repeat (8) @(negedge clk);
      check("R6", "in-region write stalled", rq_stall[1], 1);
      reg_write(2'd3, 32'h0);
      acked = 0;
      for (int n = 0; n < 20 && !acked; n++) begin
         @(negedge clk);
         if (rq_ack[1]) acked = 1;
      end
      rq_valid[1] = 1'b0;
      check("R6", "stalled write completes after release", acked, 1);
      if (acked) mdl_dirty[11] = 1'b1;

      // R4 freeze requested with an access in flight
      @(negedge clk);
      rq_valid[0] = 1'b1; rq_addr[0] = RB + 7 * LB; rq_we[0] = 1'b1;
      reg_sel = 2'd3; reg_wdata = 32'h2; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      acked = 0; early = 0;
      for (int n = 0; n < 12; n++) begin
         reg_read(2'd3, d);
         if (rq_ack[0]) begin acked = 1; rq_valid[0] = 1'b0; end
         else if (!acked && d[2]) early = 1;
         @(negedge clk);
      end
      check("R4", "freeze done before in-flight access ended", early, 0);
      check("R4", "in-flight access acked", acked, 1);
      if (acked) mdl_dirty[7] = 1'b1;
      wait_bit(2'd3, 2, 1'b1, "R4");
      reg_write(2'd3, 32'h0);
      wait_bit(2'd3, 2, 1'b0, "R4");

      // final flush of everything left
      run_wb(RB + 17, 32'd64, "R8");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule